// File: doc/BRIEF.md
# DMA Destination Address Counter with Address Error Detection

This block holds the destination address of each channel of a multi-channel DMA engine. Software loads a channel's 32-bit address through a write port. After every completed beat of that channel the address moves on to the next destination: up or down by the beat size, or not at all. A read of the channel always returns the address the next beat will use. The lower 29 bits of each address are also driven out as the external bus address.

Before a beat's address is stepped, it is checked. The check looks at alignment for the beat size. On the external bus it also looks for the top reserved area. On the internal bus it requires the address to fall inside one of a parameterised set of on-chip peripheral windows. Any failure sets one global error flag. In that cycle no channel's address moves, and all channels stay frozen until software clears the flag.

When a channel's destination is a device addressed by its acknowledge signal in single-address mode, the register is not used for that beat. It is neither checked nor stepped.

Top module: `dac_dest_addr`

## Requirements
- R1: Writing `wr_data` to channel `wr_ch` with `wr_en` high makes `rd_data` and that channel's `cur_addr` slice equal `wr_data` from the next clock. A write takes priority over a step of the same channel in the same cycle.
- R2: On `beat_done[c]` with the flag clear and no fault anywhere, channel c's address steps by the beat size. The size code in `xfer_size[2c+1:2c]` is 00=2, 01=4, 10=8 and 11=32 bytes. The mode code in `step_mode[2c+1:2c]` is 01=add, 10=subtract, and 00 or 11=hold.
- R3: A beat whose address has nonzero low bits under the size mask (bit 0, bits 1:0, bits 2:0 or bits 4:0 for size codes 00 to 11) sets `addr_err` on the next clock and does not step.
- R4: A beat with `ext_sel[c]`=1 whose address bits 28:26 are 3'b111 sets `addr_err`. Bits 31:29 play no part in this check.
- R5: A beat with `ext_sel[c]`=0 whose address is outside every inclusive [base, limit] peripheral window sets `addr_err`.
- R6: In a cycle where any beat faults, no channel's address changes. While `addr_err` is high, `beat_done` changes no address, though writes still take effect.
- R7: `ext_addr[29c+28:29c]` equals bits 28:0 of channel c's address at all times.
- R8: While `ack_dest[c]`=1, a beat on channel c neither checks nor changes its address.
- R9: `err_clr` clears `addr_err` on the next clock. Reset clears `addr_err` and leaves the address registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the error flag |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel selected for a write |
| wr_data | input | ADDR_W | Address value to write |
| rd_ch | input | CH_W | Channel selected for a read |
| rd_data | output | ADDR_W | Current address of the read channel |
| xfer_size | input | 2*NUM_CH | Per-channel beat size code |
| step_mode | input | 2*NUM_CH | Per-channel step direction code |
| beat_done | input | NUM_CH | Per-channel beat completion strobe |
| ext_sel | input | NUM_CH | 1: external bus, 0: internal peripheral bus |
| ack_dest | input | NUM_CH | 1: destination is an acknowledge-addressed device |
| err_clr | input | 1 | Clears the global error flag |
| cur_addr | output | ADDR_W*NUM_CH | All channel addresses, channel 0 lowest |
| ext_addr | output | EXT_W*NUM_CH | Lower address bits for the external bus |
| addr_err | output | 1 | Global address error flag |

## Verification
The bench uses the default build: four channels, a 32-bit address, a 29-bit external address and two peripheral windows. With four channels, a fault on one channel and a clean beat on another can land in the same cycle, so the global halt can be checked against a channel that would otherwise have stepped. With two windows, the bench can step an address across the upper limit of a window into the unmapped gap, and can check a window's last legal word.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [1:0] {
        SZ_HALF = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DBL  = 2'd2,
        SZ_LINE = 2'd3
    } beat_size_e;

    typedef enum logic [1:0] {
        MV_HOLD  = 2'd0,
        MV_UP    = 2'd1,
        MV_DOWN  = 2'd2,
        MV_HOLD2 = 2'd3
    } step_dir_e;

    // Bytes moved per beat for each size code.
    function automatic logic [5:0] size_bytes(input logic [1:0] sz);
        case (beat_size_e'(sz))
            SZ_HALF: size_bytes = 6'd2;
            SZ_WORD: size_bytes = 6'd4;
            SZ_DBL:  size_bytes = 6'd8;
            default: size_bytes = 6'd32;
        endcase
    endfunction

    // Low-order bits that must be zero for a given size code.
    function automatic logic [4:0] align_mask(input logic [1:0] sz);
        logic [5:0] b;
        b = size_bytes(sz) - 6'd1;
        align_mask = b[4:0];
    endfunction

endpackage

// File: rtl/dac_addr_chk.sv
module dac_addr_chk #(
    parameter int ADDR_W     = 32,
    parameter int EXT_W      = 29,
    parameter int NUM_RANGES = 2,
    parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_BASE  = {32'hFFA0_0000, 32'hFF00_0000},
    parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_LIMIT = {32'hFFA0_0FFF, 32'hFF00_FFFF}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        sz,
    input  logic              ext_sel,
    output logic              bad_align,
    output logic              bad_area,
    output logic              bad_periph
);
    localparam int AREA_TOP = EXT_W - 1;

    logic [NUM_RANGES-1:0] hit;

    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = RANGE_BASE[r*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] HI = RANGE_LIMIT[r*ADDR_W +: ADDR_W];
        assign hit[r] = (addr >= LO) && (addr <= HI);
    end

    always_comb begin
        bad_align  = |(addr[4:0] & dac_pkg::align_mask(sz));
        bad_area   = ext_sel && (&addr[AREA_TOP -: 3]);
        bad_periph = !ext_sel && !(|hit);
    end

endmodule

// File: rtl/dac_step.sv
module dac_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        sz,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = ADDR_W'(dac_pkg::size_bytes(sz));
        case (dac_pkg::step_dir_e'(mode))
            dac_pkg::MV_UP:   nxt = addr + delta;
            dac_pkg::MV_DOWN: nxt = addr - delta;
            default:          nxt = addr;
        endcase
    end

endmodule

// File: rtl/dac_dest_addr.sv
module dac_dest_addr #(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 32,
    parameter int EXT_W      = 29,
    parameter int NUM_RANGES = 2,
    parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_BASE  = {32'hFFA0_0000, 32'hFF00_0000},
    parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_LIMIT = {32'hFFA0_0FFF, 32'hFF00_FFFF},
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [ADDR_W-1:0]        wr_data,
    input  logic [CH_W-1:0]          rd_ch,
    output logic [ADDR_W-1:0]        rd_data,
    input  logic [2*NUM_CH-1:0]      xfer_size,
    input  logic [2*NUM_CH-1:0]      step_mode,
    input  logic [NUM_CH-1:0]        beat_done,
    input  logic [NUM_CH-1:0]        ext_sel,
    input  logic [NUM_CH-1:0]        ack_dest,
    input  logic                     err_clr,
    output logic [ADDR_W*NUM_CH-1:0] cur_addr,
    output logic [EXT_W*NUM_CH-1:0]  ext_addr,
    output logic                     addr_err
);

    typedef struct packed {
        logic [NUM_CH-1:0][ADDR_W-1:0] addr;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0][ADDR_W-1:0] nxt_addr;
    logic [NUM_CH-1:0]             used;
    logic [NUM_CH-1:0]             fault;
    logic                          any_fault;
    logic                          live;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic b_align, b_area, b_periph;

        dac_addr_chk #(
            .ADDR_W     (ADDR_W),
            .EXT_W      (EXT_W),
            .NUM_RANGES (NUM_RANGES),
            .RANGE_BASE (RANGE_BASE),
            .RANGE_LIMIT(RANGE_LIMIT)
        ) u_chk (
            .addr      (st_q.addr[c]),
            .sz        (xfer_size[2*c +: 2]),
            .ext_sel   (ext_sel[c]),
            .bad_align (b_align),
            .bad_area  (b_area),
            .bad_periph(b_periph)
        );

        dac_step #(.ADDR_W(ADDR_W)) u_step (
            .addr(st_q.addr[c]),
            .sz  (xfer_size[2*c +: 2]),
            .mode(step_mode[2*c +: 2]),
            .nxt (nxt_addr[c])
        );

        // A beat only touches the register when the address is really used.
        assign used[c]  = beat_done[c] && !ack_dest[c];
        assign fault[c] = used[c] && (b_align || b_area || b_periph);

        assign cur_addr[c*ADDR_W +: ADDR_W] = st_q.addr[c];
        assign ext_addr[c*EXT_W +: EXT_W]   = st_q.addr[c][EXT_W-1:0];
    end

    assign any_fault = |fault;
    assign live      = rst_n && !st_q.err;

    always_comb begin
        st_d = st_q;

        if (err_clr) begin
            st_d.err = 1'b0;
        end
        if (live && any_fault) begin
            st_d.err = 1'b1;
        end

        for (int c = 0; c < NUM_CH; c++) begin
            if (live && !any_fault && used[c]) begin
                st_d.addr[c] = nxt_addr[c];
            end
            if (wr_en && (wr_ch == CH_W'(c))) begin
                st_d.addr[c] = wr_data;
            end
        end

        if (!rst_n) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                rd_data = st_q.addr[c];
            end
        end
    end

    assign addr_err = st_q.err;

endmodule

// File: rtl/dac_dest_addr_chk.sv
module dac_dest_addr_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 29
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [2*NUM_CH-1:0]      xfer_size,
    input logic [NUM_CH-1:0]        beat_done,
    input logic [NUM_CH-1:0]        ext_sel,
    input logic [NUM_CH-1:0]        ack_dest,
    input logic                     err_clr,
    input logic [ADDR_W*NUM_CH-1:0] cur_addr,
    input logic                     addr_err
);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err && !err_clr |=> addr_err);

    p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err && !wr_en |=> $stable(cur_addr));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err && err_clr |=> !addr_err);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
        p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ack_dest[c] && !wr_en |=> $stable(cur_addr[c*ADDR_W +: ADDR_W]));

        p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
            beat_done[c] && !ack_dest[c] && !addr_err &&
            ((cur_addr[c*ADDR_W +: 5] & dac_pkg::align_mask(xfer_size[2*c +: 2])) != 5'd0)
            |=> addr_err);

        p_area_r4: assert property (@(posedge clk) disable iff (!rst_n)
            beat_done[c] && !ack_dest[c] && !addr_err && ext_sel[c] &&
            (cur_addr[c*ADDR_W + EXT_W - 3 +: 3] == 3'b111)
            |=> addr_err);
    end

endmodule

bind dac_dest_addr dac_dest_addr_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .EXT_W (EXT_W)
) u_dac_chk (.*);

// File: tb/tb_dac_dest_addr.sv
module tb_dac_dest_addr;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [1:0]        wr_ch;
    logic [31:0]       wr_data;
    logic [1:0]        rd_ch;
    logic [31:0]       rd_data;
    logic [2*NCH-1:0]  xfer_size;
    logic [2*NCH-1:0]  step_mode;
    logic [NCH-1:0]    beat_done;
    logic [NCH-1:0]    ext_sel;
    logic [NCH-1:0]    ack_dest;
    logic              err_clr;
    logic [32*NCH-1:0] cur_addr;
    logic [29*NCH-1:0] ext_addr;
    logic              addr_err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    dac_dest_addr dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int ch);
        return cur_addr[ch*32 +: 32];
    endfunction

    task automatic cfg(input int ch, input logic [1:0] sz, input logic [1:0] md,
                       input logic ext, input logic ack);
        xfer_size[ch*2 +: 2] = sz;
        step_mode[ch*2 +: 2] = md;
        ext_sel[ch]  = ext;
        ack_dest[ch] = ack;
    endtask

    task automatic wr(input int ch, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic beat(input logic [NCH-1:0] m);
        @(negedge clk);
        beat_done = m;
        @(negedge clk);
        beat_done = '0;
    endtask

    task automatic clear_err;
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
        xfer_size = '0; step_mode = '0; beat_done = '0; ext_sel = '1;
        ack_dest = '0; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 flag after reset", 32'(addr_err), 32'd0);
    endtask

    task automatic t_rw;
        wr(2, 32'h1234_5678);
        rd_ch = 2'd2; #1;
        chk("R1 read back", rd_data, 32'h1234_5678);
        chk("R1 cur_addr slice", addr_of(2), 32'h1234_5678);
        // write and beat on same channel in same cycle: write wins
        cfg(2, 2'b01, 2'b01, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'd2; wr_data = 32'h0000_0800; beat_done = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; beat_done = '0;
        chk("R1 write beats step", addr_of(2), 32'h0000_0800);
    endtask

    task automatic t_step;
        cfg(0, 2'b01, 2'b01, 1'b1, 1'b0);
        wr(0, 32'h1000_0000);
        beat(4'b0001);
        chk("R2 up by 4", addr_of(0), 32'h1000_0004);
        beat(4'b0001); beat(4'b0001);
        chk("R2 up by 4 x3", addr_of(0), 32'h1000_000C);
        cfg(1, 2'b10, 2'b10, 1'b1, 1'b0);
        wr(1, 32'h0200_0040);
        beat(4'b0010);
        chk("R2 down by 8", addr_of(1), 32'h0200_0038);
        cfg(3, 2'b11, 2'b01, 1'b1, 1'b0);
        wr(3, 32'h0000_0100);
        beat(4'b1000);
        chk("R2 up by 32", addr_of(3), 32'h0000_0120);
        cfg(3, 2'b00, 2'b00, 1'b1, 1'b0);
        wr(3, 32'h0000_0202);
        beat(4'b1000);
        chk("R2 hold mode 00", addr_of(3), 32'h0000_0202);
        cfg(3, 2'b00, 2'b11, 1'b1, 1'b0);
        beat(4'b1000);
        chk("R2 hold mode 11", addr_of(3), 32'h0000_0202);
        cfg(3, 2'b00, 2'b10, 1'b1, 1'b0);
        wr(3, 32'h0000_0000);
        beat(4'b1000);
        chk("R2 down by 2 wraps", addr_of(3), 32'hFFFF_FFFE);
        chk("R2 no error", 32'(addr_err), 32'd0);
    endtask

    task automatic t_align_halt;
        cfg(0, 2'b01, 2'b01, 1'b1, 1'b0);
        cfg(1, 2'b01, 2'b01, 1'b1, 1'b0);
        wr(0, 32'h1000_0000);
        wr(1, 32'h1000_0002);
        beat(4'b0011);
        chk("R3 misaligned word flags", 32'(addr_err), 32'd1);
        chk("R3 faulty channel holds", addr_of(1), 32'h1000_0002);
        chk("R6 clean channel held in fault cycle", addr_of(0), 32'h1000_0000);
        beat(4'b0001);
        chk("R6 beat ignored while flagged", addr_of(0), 32'h1000_0000);
        wr(1, 32'h1000_0010);
        chk("R6 write works while flagged", addr_of(1), 32'h1000_0010);
        clear_err;
        chk("R9 clear drops flag", 32'(addr_err), 32'd0);
        beat(4'b0001);
        chk("R9 steps after clear", addr_of(0), 32'h1000_0004);
        // 32-byte size needs bits 4:0 zero
        cfg(2, 2'b11, 2'b01, 1'b1, 1'b0);
        wr(2, 32'h0000_0010);
        beat(4'b0100);
        chk("R3 line size bit 4 flags", 32'(addr_err), 32'd1);
        clear_err;
        // 16-bit size only needs bit 0 zero
        cfg(2, 2'b00, 2'b01, 1'b1, 1'b0);
        wr(2, 32'h0000_0012);
        beat(4'b0100);
        chk("R3 half size accepts 0x12", 32'(addr_err), 32'd0);
        chk("R3 half size steps", addr_of(2), 32'h0000_0014);
    endtask

    task automatic t_area;
        cfg(1, 2'b01, 2'b01, 1'b1, 1'b0);
        wr(1, 32'h1C00_0000);
        beat(4'b0010);
        chk("R4 top area flags", 32'(addr_err), 32'd1);
        clear_err;
        wr(1, 32'hE000_0000);
        beat(4'b0010);
        chk("R4 bits 31:29 ignored", 32'(addr_err), 32'd0);
        chk("R7 ext addr drops top bits", 32'(ext_addr[29 +: 29]), 32'h0000_0004);
        chk("R7 cur addr keeps top bits", addr_of(1), 32'hE000_0004);
        cfg(1, 2'b01, 2'b01, 1'b0, 1'b0);
        wr(1, 32'h1C00_0000);
        chk("R7 ext addr of 0x1C000000", 32'(ext_addr[29 +: 29]), 32'h1C00_0000);
    endtask

    task automatic t_periph;
        cfg(0, 2'b01, 2'b01, 1'b0, 1'b0);
        wr(0, 32'hFF00_0010);
        beat(4'b0001);
        chk("R5 inside window ok", addr_of(0), 32'hFF00_0014);
        wr(0, 32'hFF00_FFFC);
        beat(4'b0001);
        chk("R5 last word ok", 32'(addr_err), 32'd0);
        chk("R5 steps past limit", addr_of(0), 32'hFF01_0000);
        beat(4'b0001);
        chk("R5 outside window flags", 32'(addr_err), 32'd1);
        clear_err;
        wr(0, 32'hFFA0_0800);
        beat(4'b0001);
        chk("R5 second window ok", addr_of(0), 32'hFFA0_0804);
        chk("R5 no flag second window", 32'(addr_err), 32'd0);
    endtask

    task automatic t_ack;
        cfg(3, 2'b01, 2'b01, 1'b1, 1'b1);
        wr(3, 32'h1C00_0003);
        beat(4'b1000);
        chk("R8 no check on ack device", 32'(addr_err), 32'd0);
        chk("R8 no step on ack device", addr_of(3), 32'h1C00_0003);
        cfg(3, 2'b01, 2'b01, 1'b1, 1'b0);
    endtask

    task automatic t_reset_keep;
        wr(2, 32'hABCD_0040);
        cfg(1, 2'b01, 2'b01, 1'b1, 1'b0);
        wr(1, 32'h0000_0001);
        beat(4'b0010);
        chk("R9 flag set before reset", 32'(addr_err), 32'd1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset clears flag", 32'(addr_err), 32'd0);
        chk("R9 reset keeps address", addr_of(2), 32'hABCD_0040);
    endtask

    initial begin
        t_reset;
        t_rw;
        t_step;
        t_align_halt;
        t_area;
        t_periph;
        t_ack;
        t_reset_keep;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule